// File: doc/BRIEF.md
# Multi-line Receive Character Silo

The silo gathers characters from up to sixteen serial receivers into a single shared queue. Every receiver hands over a byte with a one-cycle strobe, along with its parity-error and framing-error flags. The silo tags each byte with the number of the line it came from and with its error status. The host drains the queue through one next-character register. Each read of that register removes one entry. Bit 15 of the returned word tells the host whether a character was present, so the host can keep reading until a word comes back with bit 15 clear.

Each line owns a one-entry holding slot. When several slots are pending at once, the lowest-numbered line is moved into the queue first, one line per cycle. When the queue is full, an incoming character is discarded, and the next character that is stored carries the overrun flag. A character that replaces an unserved character in its line's slot also carries the overrun flag.

The receive interrupt request is paced by a writable alarm level. The request is asserted while receive interrupts are enabled and the fill level is at or above the alarm level. An alarm level of zero raises the request as soon as one character is waiting.

Top module: `rx_silo_top`

## Requirements
- R1: After reset the queue is empty, the interrupt request is low, and the control/status register (address 0) and the alarm register (address 2) both read 0.
- R2: A next-character word (address 1) holding a character has bit 15 = 1, bits 11:8 = line number, bits 7:0 = data byte, bit 12 = parity error, bit 13 = framing error and bit 14 = overrun.
- R3: Characters leave the queue in the order in which they entered it.
- R4: When several lines present characters in the same cycle, they are stored in ascending line order, one per cycle.
- R5: With 64 entries stored, further characters are dropped, and the next character stored afterwards has bit 14 set.
- R6: Reading the next-character register while the queue is empty returns 0x0000 and removes nothing.
- R7: With a nonzero alarm level A and interrupts enabled, the request is high while the fill level is at least A, and low while it is below A.
- R8: With the alarm level 0 and interrupts enabled, the request is high while at least one character is queued, and low when the queue is empty.
- R9: With the enable bit (control/status bit 6) clear, the request stays low whatever the fill level.
- R10: Writing the control/status register sets the line select (bits 3:0) and the enable bit (bit 6), and both read back at the same positions.
- R11: A character that arrives on a line whose previous character has not yet been queued replaces it and is stored with bit 14 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb_i | input | NUM_LINES | Per-line character strobe, one cycle per character |
| line_data_i | input | NUM_LINES*8 | Per-line received bytes, line n in bits 8n+7:8n |
| line_perr_i | input | NUM_LINES | Per-line parity-error flag, qualified by the strobe |
| line_ferr_i | input | NUM_LINES | Per-line framing-error (break) flag, qualified by the strobe |
| reg_wr_i | input | 1 | Host register write |
| reg_rd_i | input | 1 | Host register read; data appears one cycle later |
| reg_addr_i | input | 2 | Register select: 0 control/status, 1 next character, 2 alarm |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
Some properties are checked by assertions on every cycle. The fill level never passes the queue depth. A full queue with no read stays full. At most one line is granted per cycle, and it is always the lowest pending line. An empty read never yields a valid word. The request is never high without the enable bit set or with an empty queue. Other behaviour is shown only by the bench's scenarios: the exact word layout, the ordering among lines that strobe together, the overrun flag after a drop or a slot overwrite, and where the request switches for a given alarm level.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int LINE_W = 4;
  localparam int DATA_W = 8;
  localparam int WORD_W = 16;
  localparam int CSR_EN_BIT = 6;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [1:0] {
    REG_CSR   = 2'd0,
    REG_NXCH  = 2'd1,
    REG_ALARM = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        stb_i,
  input  logic [NUM_LINES*DATA_W-1:0] data_i,
  input  logic [NUM_LINES-1:0]        perr_i,
  input  logic [NUM_LINES-1:0]        ferr_i,
  output logic                        gnt_valid_o,
  output rx_entry_t                   gnt_entry_o
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] ovr_q;
  logic [NUM_LINES-1:0] perr_q;
  logic [NUM_LINES-1:0] ferr_q;
  logic [DATA_W-1:0]    data_q [NUM_LINES];
  logic [NUM_LINES-1:0] gnt_vec;
  logic [LINE_W-1:0]    gnt_idx;

  // lowest pending line wins
  always_comb begin
    gnt_vec = '0;
    gnt_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        gnt_vec    = '0;
        gnt_vec[i] = 1'b1;
        gnt_idx    = LINE_W'(i);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q[g] <= 1'b0;
          ovr_q[g]  <= 1'b0;
          perr_q[g] <= 1'b0;
          ferr_q[g] <= 1'b0;
          data_q[g] <= '0;
        end else if (stb_i[g]) begin
          pend_q[g] <= 1'b1;
          ovr_q[g]  <= pend_q[g] & ~gnt_vec[g];
          perr_q[g] <= perr_i[g];
          ferr_q[g] <= ferr_i[g];
          data_q[g] <= data_i[g*DATA_W +: DATA_W];
        end else if (gnt_vec[g]) begin
          pend_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  assign gnt_valid_o       = |pend_q;
  assign gnt_entry_o.ovr   = ovr_q[gnt_idx];
  assign gnt_entry_o.ferr  = ferr_q[gnt_idx];
  assign gnt_entry_o.perr  = perr_q[gnt_idx];
  assign gnt_entry_o.line  = gnt_idx;
  assign gnt_entry_o.data  = data_q[gnt_idx];

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_vec));
  p_grant_lowest_r4: assert property (@(posedge clk) disable iff (rst)
    gnt_valid_o |-> ((pend_q & (gnt_vec - 1'b1)) == '0) && ((gnt_vec & pend_q) != '0));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req_i,
  input  rx_entry_t     wr_entry_i,
  input  logic          pop_req_i,
  output rx_entry_t     rd_entry_o,
  output logic          rd_valid_o,
  output logic [CW-1:0] count_o
);
  rx_entry_t     mem [DEPTH];
  rx_entry_t     rd_q;
  rx_entry_t     wr_word;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          lost_q, rd_valid_q;
  logic          full, empty, wr_ok, pop_ok;

  assign full   = (count_q == CW'(DEPTH));
  assign empty  = (count_q == '0);
  assign wr_ok  = wr_req_i & ~full;
  assign pop_ok = pop_req_i & ~empty;

  always_comb begin
    wr_word     = wr_entry_i;
    wr_word.ovr = wr_entry_i.ovr | lost_q;
  end

  // storage: no reset, synchronous read, suits block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wr_word;
    if (pop_ok) rd_q <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      count_q    <= '0;
      lost_q     <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      count_q <= count_q + CW'(wr_ok) - CW'(pop_ok);
      if (wr_req_i && full) lost_q <= 1'b1;
      else if (wr_ok) lost_q <= 1'b0;
      if (pop_req_i) rd_valid_q <= pop_ok;
    end
  end

  assign rd_entry_o = rd_q;
  assign rd_valid_o = rd_valid_q;
  assign count_o    = count_q;

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  p_full_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_req_i && full && !pop_req_i) |=> (count_q == CW'(DEPTH)));
  p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_req_i && empty) |=> !rd_valid_q);
endmodule

// File: rtl/rx_host_regs.sv
module rx_host_regs
  import rx_silo_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic [CW-1:0]     count_i,
  input  rx_entry_t         fifo_entry_i,
  input  logic              fifo_valid_i,
  output logic              pop_req_o,
  output logic              irq_o
);
  logic [LINE_W-1:0] linesel_q;
  logic              en_q;
  logic [CW-1:0]     alarm_q;
  logic [CW-1:0]     thr;
  logic              nx_sel_q;
  logic [WORD_W-1:0] other_q;
  logic              irq_q;

  assign pop_req_o = reg_rd_i && (reg_addr_i == REG_NXCH);
  assign thr       = (alarm_q == '0) ? CW'(1) : alarm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      linesel_q <= '0;
      en_q      <= 1'b0;
      alarm_q   <= '0;
      nx_sel_q  <= 1'b0;
      other_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        case (reg_addr_i)
          REG_CSR: begin
            linesel_q <= reg_wdata_i[LINE_W-1:0];
            en_q      <= reg_wdata_i[CSR_EN_BIT];
          end
          REG_ALARM: alarm_q <= reg_wdata_i[CW-1:0];
          default: ;
        endcase
      end
      if (reg_rd_i) begin
        nx_sel_q <= (reg_addr_i == REG_NXCH);
        case (reg_addr_i)
          REG_CSR: begin
            other_q                  <= '0;
            other_q[LINE_W-1:0]      <= linesel_q;
            other_q[CSR_EN_BIT]      <= en_q;
          end
          REG_ALARM: other_q <= WORD_W'(alarm_q);
          default:   other_q <= '0;
        endcase
      end
      irq_q <= en_q && (count_i >= thr);
    end
  end

  assign reg_rdata_o = nx_sel_q ? (fifo_valid_i ? {1'b1, fifo_entry_i} : '0) : other_q;
  assign irq_o       = irq_q;

  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(en_q));
  p_irq_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(count_i) != '0));
endmodule

// File: rtl/rx_silo_top.sv
module rx_silo_top
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_LINES-1:0]   line_stb_i,
  input  logic [NUM_LINES*8-1:0] line_data_i,
  input  logic [NUM_LINES-1:0]   line_perr_i,
  input  logic [NUM_LINES-1:0]   line_ferr_i,
  input  logic                   reg_wr_i,
  input  logic                   reg_rd_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [15:0]            reg_wdata_i,
  output logic [15:0]            reg_rdata_o,
  output logic                   rx_irq_o
);
  logic          gnt_valid;
  rx_entry_t     gnt_entry;
  rx_entry_t     fifo_entry;
  logic          fifo_valid;
  logic          pop_req;
  logic [CW-1:0] count;

  rx_line_hold #(.NUM_LINES(NUM_LINES)) u_hold (
    .clk(clk), .rst(rst),
    .stb_i(line_stb_i), .data_i(line_data_i),
    .perr_i(line_perr_i), .ferr_i(line_ferr_i),
    .gnt_valid_o(gnt_valid), .gnt_entry_o(gnt_entry)
  );

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_req_i(gnt_valid), .wr_entry_i(gnt_entry),
    .pop_req_i(pop_req),
    .rd_entry_o(fifo_entry), .rd_valid_o(fifo_valid),
    .count_o(count)
  );

  rx_host_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .count_i(count), .fifo_entry_i(fifo_entry), .fifo_valid_i(fifo_valid),
    .pop_req_o(pop_req), .irq_o(rx_irq_o)
  );
endmodule

// File: tb/rx_silo_top_tb_top.sv
module rx_silo_top_tb_top;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] stb = '0;
  logic [NL*8-1:0] ldata = '0;
  logic [NL-1:0] perr = '0;
  logic [NL-1:0] ferr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [1:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] expq [$];

  always #5 clk = ~clk;

  rx_silo_top dut_i (
    .clk(clk), .rst(rst),
    .line_stb_i(stb), .line_data_i(ldata),
    .line_perr_i(perr), .line_ferr_i(ferr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(int ln, logic [7:0] d, bit pe, bit fe, bit ov);
    return {1'b1, ov, fe, pe, 4'(ln), d};
  endfunction

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  // driver: one character on one line, expectation pushed to scoreboard
  task automatic send(int ln, logic [7:0] d, bit pe, bit fe, bit ov, bit expect_it);
    @(negedge clk);
    stb[ln] = 1'b1; ldata[ln*8 +: 8] = d; perr[ln] = pe; ferr[ln] = fe;
    @(negedge clk);
    stb = '0; perr = '0; ferr = '0;
    if (expect_it) expq.push_back(word(ln, d, pe, fe, ov));
  endtask

  // monitor: pop n words from the design and compare against scoreboard
  task automatic drain(int n, string req);
    logic [15:0] v;
    for (int i = 0; i < n; i++) begin
      reg_read(2'd1, v);
      if (expq.size() == 0) chk(req, v, 16'hxxxx);
      else chk(req, v, expq.pop_front());
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle(2);

    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    reg_read(2'd0, v); chk("R1 csr", v, 16'h0000);
    reg_read(2'd2, v); chk("R1 alarm", v, 16'h0000);
    // R6 empty read
    reg_read(2'd1, v); chk("R6 empty read", v, 16'h0000);

    // R10 csr line select + enable
    reg_write(2'd0, 16'h0045);
    reg_read(2'd0, v); chk("R10 csr readback", v, 16'h0045);

    // R8 alarm 0, R2 word layout
    send(2, 8'h41, 0, 0, 0, 1);
    settle(3);
    chk("R8 irq one char", {15'd0, irq}, 16'd1);
    drain(1, "R2 plain word");
    settle(3);
    chk("R8 irq empty", {15'd0, irq}, 16'd0);

    // R2 error bits, R3 order
    send(9, 8'h10, 1, 0, 0, 1);
    send(10, 8'h7F, 0, 1, 0, 1);
    send(5, 8'h33, 0, 0, 0, 1);
    settle(4);
    chk("R2 parity layout", expq[0], 16'h9910);
    drain(3, "R3 R2 ordered errors");

    // R4 same-cycle lines 12, 7, 1
    @(negedge clk);
    stb = 16'h1082; ldata[12*8 +: 8] = 8'hC1; ldata[7*8 +: 8] = 8'h71; ldata[1*8 +: 8] = 8'h11;
    @(negedge clk); stb = '0;
    expq.push_back(word(1, 8'h11, 0, 0, 0));
    expq.push_back(word(7, 8'h71, 0, 0, 0));
    expq.push_back(word(12, 8'hC1, 0, 0, 0));
    settle(5);
    drain(3, "R4 ascending lines");

    // R11 overwrite of an unserved slot on line 15
    @(negedge clk);
    stb = '1;
    for (int i = 0; i < NL; i++) ldata[i*8 +: 8] = 8'(8'h20 + i);
    @(negedge clk);
    stb = 16'h8000; ldata[15*8 +: 8] = 8'h99;
    @(negedge clk); stb = '0;
    for (int i = 0; i < NL - 1; i++) expq.push_back(word(i, 8'(8'h20 + i), 0, 0, 0));
    expq.push_back(16'hCF99);
    settle(20);
    drain(16, "R11 R4 overwrite");

    // R9 disabled interrupt
    reg_write(2'd0, 16'h0000);
    send(6, 8'h66, 0, 0, 0, 1);
    settle(4);
    chk("R9 irq disabled", {15'd0, irq}, 16'd0);
    drain(1, "R9 drain");

    // R7 threshold 32, R5 overflow
    reg_write(2'd2, 16'd32);
    reg_write(2'd0, 16'h0040);
    reg_read(2'd2, v); chk("R7 alarm readback", v, 16'd32);
    for (int i = 0; i < 31; i++) send(3, 8'(i), 0, 0, 0, 1);
    settle(4);
    chk("R7 below alarm", {15'd0, irq}, 16'd0);
    send(3, 8'd31, 0, 0, 0, 1);
    settle(4);
    chk("R7 at alarm", {15'd0, irq}, 16'd1);
    for (int i = 32; i < 66; i++) send(3, 8'(i), 0, 0, 0, i < 64);
    settle(4);
    drain(1, "R5 first after fill");
    send(4, 8'hAA, 0, 0, 1, 1);
    settle(4);
    drain(33, "R5 R3 full drain part");
    settle(3);
    chk("R7 below alarm after drain", {15'd0, irq}, 16'd0);
    drain(30, "R5 R3 drain rest");
    chk("R5 overrun word queued", expq[0], 16'hC4AA);
    drain(1, "R5 overrun flag");
    reg_read(2'd1, v); chk("R6 empty after drain", v, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule